// File: doc/BRIEF.md
# Eighth-Order LPC Reconstruction Filter

This block turns a frame of prediction residuals back into audio samples using a fixed eighth-order linear predictor. Software programs five parameter registers (where the warm-up samples, the quantized coefficients and the residuals live, how far the prediction is shifted right, and how many samples the frame holds) and then pulses a start input. The block then fetches everything it needs through its own memory master port.

The block first reads the eight coefficients and the eight warm-up samples. For every later sample it runs one multiplier over the eight taps in turn, shifts the 32-bit sum right arithmetically, fetches the matching residual, and adds it. It writes the result over that residual and feeds the result into its sample history, so the history always holds the eight most recent samples. When the last sample of the frame has been written back, the done output rises. It stays high until the next start.

Top module: `lpc_rec_filter`

## Requirements
- R1: Register writes (reg_we high) set the parameters by reg_addr: 0 warm-up base address, 1 coefficient base address, 2 residual base address, 3 shift (bits 4:0), 4 frame length (bits 15:0). A one-cycle start pulse begins a frame when no frame is running.
- R2: A frame begins with eight reads at coefficient base + 0..7, followed by eight reads at warm-up base + 0..7, before any residual access. Word k of each group holds coefficient k or warm-up sample k.
- R3: The prediction for sample i is the sum over j = 0..7 of coef[j] * sample[i-1-j]. Coefficients are the low 14 bits of their word as a signed value. Samples are the low 16 bits as a signed value. The sum wraps at 32 bits.
- R4: The prediction is shifted right arithmetically by the shift value (0 to 31), so negative sums round toward minus infinity.
- R5: For i = 8 .. length-1, the block reads the residual at residual base + i as a 32-bit signed word and adds it to the shifted prediction. It keeps the low 16 bits of the result and writes them back, sign-extended to 32 bits, to residual base + i. Each sample gets exactly one read and one write, and residual slots 0..7 are never written.
- R6: Warm-up samples 0..7 are taken as samples 0..7 of the frame. Each rebuilt sample becomes sample[i-1] for the next prediction, and the oldest sample is dropped.
- R7: A frame length of 8 or less causes no residual reads and no writes. Done rises after the sixteen load reads.
- R8: Done is low after reset and while a frame runs. It rises after the last write completes and stays high, with the bus idle, until the next start.
- R9: Each bus transfer spends one cycle with mem_sel high and mem_enable low. It then holds mem_sel and mem_enable high, with address, direction and write data stable, until mem_ready is high. mem_enable is never high without mem_sel.
- R10: The rebuilt samples do not depend on how many wait cycles the memory inserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Parameter register write strobe |
| reg_addr | input | 3 | Parameter register select |
| reg_wdata | input | 32 | Parameter write data |
| start | input | 1 | Begin a frame |
| done | output | 1 | Frame finished, held until next start |
| mem_sel | output | 1 | Bus transfer in progress |
| mem_enable | output | 1 | Bus access phase |
| mem_write | output | 1 | Transfer is a write |
| mem_addr | output | ADDR_W (16) | Word address |
| mem_wdata | output | 32 | Write data (rebuilt sample, sign-extended) |
| mem_rdata | input | 32 | Read data |
| mem_ready | input | 1 | Memory completes the access |

## Verification
The filter is driven with all-zero coefficients, which isolates the residual path and the 16-bit truncation. A single unit coefficient at tap 0 and then at tap 7 shows whether tap ordering and history shifting are correct. A negative coefficient with shifts of 1 and 31 separates an arithmetic shift from a logical one. Full-scale coefficients and samples force 32-bit wrap and 16-bit truncation. Realistic mixed coefficients are run with and without wait states to show that bus timing does not affect the result. Frame lengths of 0 and 8, changed base addresses, and a held done state cover the edges of the control sequence.

// File: rtl/lpc_rec_pkg.sv
package lpc_rec_pkg;

    localparam int PRED_ORDER  = 8;
    localparam int SAMPLE_BITS = 16;
    localparam int COEF_BITS   = 14;
    localparam int SUM_BITS    = 32;
    localparam int WORD_BITS   = 32;
    localparam int LENGTH_BITS = 16;
    localparam int SHAMT_BITS  = 5;
    localparam int CFG_SEL_W   = 3;

    localparam logic [CFG_SEL_W-1:0] CFG_WARM_BASE  = 3'd0;
    localparam logic [CFG_SEL_W-1:0] CFG_COEF_BASE  = 3'd1;
    localparam logic [CFG_SEL_W-1:0] CFG_RESID_BASE = 3'd2;
    localparam logic [CFG_SEL_W-1:0] CFG_SHAMT      = 3'd3;
    localparam logic [CFG_SEL_W-1:0] CFG_LENGTH     = 3'd4;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FETCH_COEF,
        PH_FETCH_WARM,
        PH_ACCUM,
        PH_SCALE,
        PH_FETCH_RESID,
        PH_STORE,
        PH_FINISHED
    } phase_e;

    typedef enum logic [1:0] {
        XFER_IDLE,
        XFER_SETUP,
        XFER_ACCESS
    } xfer_e;

    typedef struct packed {
        logic                 is_write;
        logic [WORD_BITS-1:0] payload;
    } xfer_cmd_t;

    function automatic logic [WORD_BITS-1:0] widen_sample(input logic [SAMPLE_BITS-1:0] s);
        return {{(WORD_BITS-SAMPLE_BITS){s[SAMPLE_BITS-1]}}, s};
    endfunction

endpackage

// File: rtl/lpc_bus_master.sv
module lpc_bus_master
    import lpc_rec_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = WORD_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rsp_data,
    output logic              mem_sel,
    output logic              mem_enable,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);

    xfer_e             xstate;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [DATA_W-1:0] wdata_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            xstate   <= XFER_IDLE;
            ack      <= 1'b0;
            rsp_data <= '0;
            addr_q   <= '0;
            write_q  <= 1'b0;
            wdata_q  <= '0;
        end else begin
            ack <= 1'b0;
            case (xstate)
                XFER_IDLE: begin
                    if (req) begin
                        addr_q  <= req_addr;
                        write_q <= req_write;
                        wdata_q <= req_wdata;
                        xstate  <= XFER_SETUP;
                    end
                end
                XFER_SETUP: begin
                    xstate <= XFER_ACCESS;
                end
                XFER_ACCESS: begin
                    if (mem_ready) begin
                        ack      <= 1'b1;
                        rsp_data <= mem_rdata;
                        xstate   <= XFER_IDLE;
                    end
                end
                default: xstate <= XFER_IDLE;
            endcase
        end
    end

    assign mem_sel    = (xstate != XFER_IDLE);
    assign mem_enable = (xstate == XFER_ACCESS);
    assign mem_write  = write_q;
    assign mem_addr   = addr_q;
    assign mem_wdata  = wdata_q;

endmodule

// File: rtl/lpc_tap_store.sv
module lpc_tap_store
    import lpc_rec_pkg::*;
#(
    parameter int ORDER  = PRED_ORDER,
    parameter int SMP_W  = SAMPLE_BITS,
    parameter int COEF_W = COEF_BITS,
    parameter int IDX_W  = $clog2(ORDER)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              coef_we,
    input  logic [IDX_W-1:0]  coef_idx,
    input  logic [COEF_W-1:0] coef_in,
    input  logic              push,
    input  logic [SMP_W-1:0]  push_smp,
    input  logic [IDX_W-1:0]  tap_sel,
    output logic [COEF_W-1:0] tap_coef,
    output logic [SMP_W-1:0]  tap_smp
);

    logic [COEF_W-1:0] coef_w [ORDER];
    logic [SMP_W-1:0]  hist_w [ORDER];

    for (genvar k = 0; k < ORDER; k++) begin : g_tap
        logic [COEF_W-1:0] coef_r;
        logic [SMP_W-1:0]  hist_r;
        logic [SMP_W-1:0]  hist_nx;

        if (k == 0) begin : g_head
            assign hist_nx = push_smp;
        end else begin : g_body
            assign hist_nx = hist_w[k-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                coef_r <= '0;
                hist_r <= '0;
            end else begin
                if (coef_we && (coef_idx == IDX_W'(k))) begin
                    coef_r <= coef_in;
                end
                if (push) begin
                    hist_r <= hist_nx;
                end
            end
        end

        assign coef_w[k] = coef_r;
        assign hist_w[k] = hist_r;
    end

    assign tap_coef = coef_w[tap_sel];
    assign tap_smp  = hist_w[tap_sel];

endmodule

// File: rtl/lpc_mac_unit.sv
module lpc_mac_unit
    import lpc_rec_pkg::*;
#(
    parameter int SMP_W  = SAMPLE_BITS,
    parameter int COEF_W = COEF_BITS,
    parameter int ACC_W  = SUM_BITS
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    first,
    input  logic signed [SMP_W-1:0]  smp,
    input  logic signed [COEF_W-1:0] coef,
    output logic        [ACC_W-1:0]  acc
);

    localparam int PROD_W = SMP_W + COEF_W;

    logic signed [PROD_W-1:0] prod;
    logic        [ACC_W-1:0]  prod_ext;
    logic        [ACC_W-1:0]  base;

    assign prod     = smp * coef;
    assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    assign base     = first ? '0 : acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (en) begin
            acc <= base + prod_ext;
        end
    end

endmodule

// File: rtl/lpc_rec_filter.sv
module lpc_rec_filter
    import lpc_rec_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = WORD_BITS,
    parameter int SMP_W   = SAMPLE_BITS,
    parameter int COEF_W  = COEF_BITS,
    parameter int ACC_W   = SUM_BITS,
    parameter int LEN_W   = LENGTH_BITS,
    parameter int SHIFT_W = SHAMT_BITS,
    parameter int ORDER   = PRED_ORDER
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [CFG_SEL_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic                 start,
    output logic                 done,
    output logic                 mem_sel,
    output logic                 mem_enable,
    output logic                 mem_write,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    input  logic                 mem_ready
);

    localparam int TAP_W = $clog2(ORDER);
    localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(ORDER - 1);

    // parameter registers
    logic [ADDR_W-1:0]  warm_base, coef_base, resid_base;
    logic [SHIFT_W-1:0] shamt;
    logic [LEN_W-1:0]   frame_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            warm_base  <= '0;
            coef_base  <= '0;
            resid_base <= '0;
            shamt      <= '0;
            frame_len  <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                CFG_WARM_BASE:  warm_base  <= reg_wdata[ADDR_W-1:0];
                CFG_COEF_BASE:  coef_base  <= reg_wdata[ADDR_W-1:0];
                CFG_RESID_BASE: resid_base <= reg_wdata[ADDR_W-1:0];
                CFG_SHAMT:      shamt      <= reg_wdata[SHIFT_W-1:0];
                CFG_LENGTH:     frame_len  <= reg_wdata[LEN_W-1:0];
                default: ;
            endcase
        end
    end

    // sequencer state
    phase_e             phase;
    logic [TAP_W-1:0]   load_cnt;
    logic [TAP_W-1:0]   tap;
    logic [LEN_W-1:0]   idx;
    logic               pend;
    logic [ACC_W-1:0]   pred;
    logic [SMP_W-1:0]   out_smp;

    // datapath interconnect
    xfer_cmd_t          cmd;
    logic               bus_req, bus_ack;
    logic [ADDR_W-1:0]  req_addr;
    logic [DATA_W-1:0]  rsp_data;
    logic               coef_we, push;
    logic [SMP_W-1:0]   push_smp;
    logic [COEF_W-1:0]  tap_coef;
    logic [SMP_W-1:0]   tap_smp;
    logic [ACC_W-1:0]   acc;
    logic [ACC_W-1:0]   res_sum;
    logic               on_bus;

    assign on_bus = (phase == PH_FETCH_COEF) || (phase == PH_FETCH_WARM) ||
                    (phase == PH_FETCH_RESID) || (phase == PH_STORE);
    assign bus_req = on_bus && !pend;

    assign cmd.is_write = (phase == PH_STORE);
    assign cmd.payload  = widen_sample(out_smp);

    always_comb begin
        case (phase)
            PH_FETCH_COEF: req_addr = coef_base + ADDR_W'(load_cnt);
            PH_FETCH_WARM: req_addr = warm_base + ADDR_W'(load_cnt);
            default:       req_addr = resid_base + ADDR_W'(idx);
        endcase
    end

    assign coef_we  = (phase == PH_FETCH_COEF) && bus_ack;
    assign push     = ((phase == PH_FETCH_WARM) || (phase == PH_STORE)) && bus_ack;
    assign push_smp = (phase == PH_FETCH_WARM) ? rsp_data[SMP_W-1:0] : out_smp;
    assign res_sum  = pred + ACC_W'(rsp_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            load_cnt <= '0;
            tap      <= '0;
            idx      <= '0;
            pend     <= 1'b0;
            pred     <= '0;
            out_smp  <= '0;
        end else begin
            if (bus_req) begin
                pend <= 1'b1;
            end else if (bus_ack) begin
                pend <= 1'b0;
            end

            case (phase)
                PH_IDLE, PH_FINISHED: begin
                    if (start) begin
                        load_cnt <= '0;
                        phase    <= PH_FETCH_COEF;
                    end
                end
                PH_FETCH_COEF: begin
                    if (bus_ack) begin
                        load_cnt <= load_cnt + 1'b1;
                        if (load_cnt == LAST_TAP) begin
                            phase <= PH_FETCH_WARM;
                        end
                    end
                end
                PH_FETCH_WARM: begin
                    if (bus_ack) begin
                        load_cnt <= load_cnt + 1'b1;
                        if (load_cnt == LAST_TAP) begin
                            if (frame_len <= LEN_W'(ORDER)) begin
                                phase <= PH_FINISHED;
                            end else begin
                                idx   <= LEN_W'(ORDER);
                                tap   <= '0;
                                phase <= PH_ACCUM;
                            end
                        end
                    end
                end
                PH_ACCUM: begin
                    tap <= tap + 1'b1;
                    if (tap == LAST_TAP) begin
                        phase <= PH_SCALE;
                    end
                end
                PH_SCALE: begin
                    pred  <= ACC_W'($signed(acc) >>> shamt);
                    phase <= PH_FETCH_RESID;
                end
                PH_FETCH_RESID: begin
                    if (bus_ack) begin
                        out_smp <= res_sum[SMP_W-1:0];
                        phase   <= PH_STORE;
                    end
                end
                PH_STORE: begin
                    if (bus_ack) begin
                        if ((idx + LEN_W'(1)) == frame_len) begin
                            phase <= PH_FINISHED;
                        end else begin
                            idx   <= idx + LEN_W'(1);
                            tap   <= '0;
                            phase <= PH_ACCUM;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign done = (phase == PH_FINISHED);

    logic unused_cfg_bits;
    assign unused_cfg_bits = &{1'b0, reg_wdata};

    lpc_bus_master #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_bus (
        .clk        (clk),
        .rst        (rst),
        .req        (bus_req),
        .req_write  (cmd.is_write),
        .req_addr   (req_addr),
        .req_wdata  (cmd.payload),
        .ack        (bus_ack),
        .rsp_data   (rsp_data),
        .mem_sel    (mem_sel),
        .mem_enable (mem_enable),
        .mem_write  (mem_write),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready)
    );

    lpc_tap_store #(
        .ORDER  (ORDER),
        .SMP_W  (SMP_W),
        .COEF_W (COEF_W),
        .IDX_W  (TAP_W)
    ) u_taps (
        .clk      (clk),
        .rst      (rst),
        .coef_we  (coef_we),
        .coef_idx (load_cnt),
        .coef_in  (rsp_data[COEF_W-1:0]),
        .push     (push),
        .push_smp (push_smp),
        .tap_sel  (tap),
        .tap_coef (tap_coef),
        .tap_smp  (tap_smp)
    );

    lpc_mac_unit #(
        .SMP_W  (SMP_W),
        .COEF_W (COEF_W),
        .ACC_W  (ACC_W)
    ) u_mac (
        .clk   (clk),
        .rst   (rst),
        .en    (phase == PH_ACCUM),
        .first (tap == '0),
        .smp   (tap_smp),
        .coef  (tap_coef),
        .acc   (acc)
    );

endmodule

// File: rtl/lpc_rec_filter_chk.sv
module lpc_rec_filter_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SMP_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              done,
    input logic              mem_sel,
    input logic              mem_enable,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ready
);

    // R9
    enable_within_sel_chk: assert property (@(posedge clk) disable iff (rst)
        mem_enable |-> mem_sel);

    // R9
    setup_to_access_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_sel && !mem_enable) |=> (mem_sel && mem_enable));

    // R9
    access_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_sel && mem_enable && !mem_ready) |=>
            (mem_sel && mem_enable && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)));

    // R8
    done_bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_sel);

    // R8
    done_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R8
    done_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> !done);

    // R5
    wdata_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_sel && mem_write) |-> (mem_wdata[DATA_W-1:SMP_W-1] == {(DATA_W-SMP_W+1){mem_wdata[SMP_W-1]}}));

endmodule

bind lpc_rec_filter lpc_rec_filter_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SMP_W  (SMP_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .done       (done),
    .mem_sel    (mem_sel),
    .mem_enable (mem_enable),
    .mem_write  (mem_write),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ready  (mem_ready)
);

// File: tb/lpc_rec_filter_bench.sv
module lpc_rec_filter_bench;

    localparam int AW = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic          reg_we    = 1'b0;
    logic [2:0]    reg_addr  = '0;
    logic [31:0]   reg_wdata = '0;
    logic          start     = 1'b0;
    wire           done, mem_sel, mem_enable, mem_write;
    wire  [AW-1:0] mem_addr;
    wire  [31:0]   mem_wdata;
    wire  [31:0]   mem_rdata;
    wire           mem_ready;

    lpc_rec_filter u_lpc_rec_filter (
        .clk        (clk),
        .rst        (rst),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .start      (start),
        .done       (done),
        .mem_sel    (mem_sel),
        .mem_enable (mem_enable),
        .mem_write  (mem_write),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready)
    );

    // memory model with programmable wait cycles
    logic [31:0]   mem [0:511];
    int            wait_cfg = 0;
    int            wcnt = 0;
    int            rd_cnt = 0;
    int            wr_cnt = 0;
    logic [AW-1:0] rd_log [0:31];

    assign mem_ready = mem_sel && mem_enable && (wcnt >= wait_cfg);
    assign mem_rdata = mem[mem_addr[8:0]];

    always @(posedge clk) begin
        if (mem_sel && mem_enable) begin
            if (mem_ready) begin
                wcnt <= 0;
                if (mem_write) begin
                    mem[mem_addr[8:0]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    if (rd_cnt < 32) rd_log[rd_cnt] <= mem_addr;
                    rd_cnt <= rd_cnt + 1;
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end else begin
            wcnt <= 0;
        end
    end

    int total = 0;
    int fails = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000) begin
            fails = fails + 1;
            total = total + 1;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 190000", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int sx16(input int v);
        logic [15:0] t;
        t = v[15:0];
        return int'($signed(t));
    endfunction

    function automatic int sx14(input int v);
        logic [13:0] t;
        t = v[13:0];
        return int'($signed(t));
    endfunction

    int c_arr [8];
    int w_arr [8];
    int r_arr [256];
    int exp_s [256];
    int b_coef = 0;
    int b_warm = 16;
    int b_res  = 64;

    task automatic reg_write(input logic [2:0] a, input int d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n;
        n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk(done == 1'b1, req, "done after frame", int'(done), 1);
    endtask

    // R1 R2 R3 R5: program, run, and check one frame
    task automatic do_frame(input string req, input int shift, input int len);
        int n_out, bad;
        for (int k = 0; k < 8; k++) begin
            mem[b_coef + k] = c_arr[k];
            mem[b_warm + k] = w_arr[k];
        end
        for (int i = 0; i < len; i++) mem[b_res + i] = r_arr[i];
        for (int i = 0; i < 8; i++) exp_s[i] = sx16(w_arr[i]);
        for (int i = 8; i < len; i++) begin
            int acc, pr;
            acc = 0;
            for (int j = 0; j < 8; j++) acc += sx14(c_arr[j]) * exp_s[i-1-j];
            pr = acc >>> shift;
            exp_s[i] = sx16(pr + r_arr[i]);
        end
        rd_cnt = 0;
        wr_cnt = 0;
        reg_write(3'd0, b_warm);
        reg_write(3'd1, b_coef);
        reg_write(3'd2, b_res);
        reg_write(3'd3, shift);
        reg_write(3'd4, len);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done("R8");
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            if (int'(rd_log[k]) != b_coef + k) bad++;
            if (int'(rd_log[8 + k]) != b_warm + k) bad++;
        end
        chk(bad == 0, "R2", "load address order mismatches", bad, 0);
        n_out = (len > 8) ? len - 8 : 0;
        chk(wr_cnt == n_out, (len > 8) ? "R5" : "R7", "write count", wr_cnt, n_out);
        chk(rd_cnt == 16 + n_out, (len > 8) ? "R5" : "R7", "read count", rd_cnt, 16 + n_out);
        bad = 0;
        for (int i = 0; i < len && i < 8; i++) if (int'(mem[b_res + i]) != r_arr[i]) bad++;
        chk(bad == 0, "R5", "residual slots 0..7 changed", bad, 0);
        for (int i = 8; i < len; i++)
            chk(int'(mem[b_res + i]) == exp_s[i], req, $sformatf("sample %0d", i), int'(mem[b_res + i]), exp_s[i]);
    endtask

    task automatic t_reset;
        chk(done == 1'b0, "R8", "done after reset", int'(done), 0);
        chk(mem_sel == 1'b0, "R9", "mem_sel after reset", int'(mem_sel), 0);
        chk(mem_enable == 1'b0, "R9", "mem_enable after reset", int'(mem_enable), 0);
    endtask

    // R5: zero predictor passes residuals through, truncated to 16 bits
    task automatic t_pass_through;
        for (int k = 0; k < 8; k++) begin c_arr[k] = 0; w_arr[k] = 100 * k; end
        for (int i = 0; i < 20; i++) r_arr[i] = int'($urandom % 200001) - 100000;
        r_arr[8] = 32'h0001_7FFF;
        do_frame("R5", 0, 20);
    endtask

    // R6: tap 0 only gives a running sum of residuals
    task automatic t_lag_one;
        for (int k = 0; k < 8; k++) begin c_arr[k] = 0; w_arr[k] = k * 7 - 20; end
        c_arr[0] = 1;
        for (int i = 0; i < 24; i++) r_arr[i] = int'($urandom % 41) - 20;
        do_frame("R6", 0, 24);
    endtask

    // R3 R6: tap 7 only repeats the warm-up pattern with period eight
    task automatic t_lag_eight;
        for (int k = 0; k < 8; k++) begin c_arr[k] = 0; w_arr[k] = (k + 1) * 1111 - 4000; end
        c_arr[7] = 1;
        for (int i = 0; i < 24; i++) r_arr[i] = 0;
        r_arr[12] = 5;
        do_frame("R3", 0, 24);
    endtask

    // R4: negative sum, arithmetic shift rounds toward minus infinity
    task automatic t_signed_shift;
        for (int k = 0; k < 8; k++) begin c_arr[k] = 0; w_arr[k] = 0; end
        c_arr[0] = -3;
        w_arr[7] = 5;
        for (int i = 0; i < 16; i++) r_arr[i] = 0;
        do_frame("R4", 1, 16);
        chk(int'(mem[b_res + 8]) == -8, "R4", "-15 shifted by 1", int'(mem[b_res + 8]), -8);
        do_frame("R4", 31, 12);
        chk(int'(mem[b_res + 8]) == -1, "R4", "-15 shifted by 31", int'(mem[b_res + 8]), -1);
    endtask

    // R3: full-scale operands force 32-bit wrap and 16-bit truncation
    task automatic t_wrap;
        for (int k = 0; k < 8; k++) begin
            c_arr[k] = (k % 2 == 0) ? 8191 : -8192;
            w_arr[k] = (k % 2 == 0) ? -32768 : 32767;
        end
        c_arr[3] = 32'h7FFF_E001;
        for (int i = 0; i < 18; i++) r_arr[i] = int'($urandom);
        do_frame("R3", 2, 18);
    endtask

    // R10 R1: realistic predictor, moved bases, with and without wait cycles
    task automatic t_waits;
        c_arr = '{1260, -420, 310, -150, 85, -41, 19, -9};
        for (int k = 0; k < 8; k++) w_arr[k] = (k * 3001) % 9000 - 4500;
        for (int i = 0; i < 40; i++) r_arr[i] = int'($urandom % 601) - 300;
        b_coef = 32; b_warm = 48; b_res = 128;
        wait_cfg = 0;
        do_frame("R10", 10, 40);
        wait_cfg = 3;
        do_frame("R10", 10, 40);
        wait_cfg = 1;
        do_frame("R1", 6, 33);
        b_coef = 0; b_warm = 16; b_res = 64;
        wait_cfg = 0;
    endtask

    // R7: short frames produce no residual traffic
    task automatic t_short;
        for (int k = 0; k < 8; k++) begin c_arr[k] = 1; w_arr[k] = k; end
        for (int i = 0; i < 8; i++) r_arr[i] = 77 + i;
        do_frame("R7", 0, 8);
        do_frame("R7", 0, 0);
    endtask

    // R8: done holds until the next start, then drops
    task automatic t_done_hold;
        for (int k = 0; k < 8; k++) begin c_arr[k] = k; w_arr[k] = -k; end
        for (int i = 0; i < 10; i++) r_arr[i] = i;
        do_frame("R8", 3, 10);
        repeat (10) @(negedge clk);
        chk(done == 1'b1, "R8", "done held", int'(done), 1);
        chk(mem_sel == 1'b0, "R8", "bus idle while done", int'(mem_sel), 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R8", "done after restart", int'(done), 0);
        wait_done("R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_pass_through();
        t_lag_one();
        t_lag_eight();
        t_signed_shift();
        t_wrap();
        t_waits();
        t_short();
        t_done_hold();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule